// File: doc/BRIEF.md
# I2C Target with Host-Paced Clock Stretching

This block is an I2C bus target that runs from the system clock and samples the open-drain SCL and SDA lines through synchronizers. It recognises one programmed 7-bit address and then either accepts bytes from the bus controller or sends bytes to it. At every point where a decision is needed, it pulls SCL low and waits for the host. Those points are an address match, a byte received, and a byte sent together with the controller's acknowledge. The host sees a pending flag and a status code, reads the received byte, and answers with one command: acknowledge, not-acknowledge or continue. A transmit byte travels with the command.

A configuration bit makes the target HS-capable. When it is set, every received data byte is acknowledged automatically and the stretch comes after the acknowledge bit. The host sequence for receiving is then the same whether or not the bus actually switches speed. A master code of the form 0000_1xxx raises a pad-control output that selects high-speed filtering and drive. The target still answers its own address after the repeated START that follows, and the pad control returns to normal on STOP.

Top module: `i2ct_target`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o, pend_o and pad_hs_o are 0 and stat_o is 0 (none).
- R2: A received address byte whose upper seven bits equal cfg_addr_i causes SCL to be held low before the acknowledge bit, with pend_o=1 and stat_o=1 (bit 0 of the byte = 0, write) or stat_o=2 (bit 0 = 1, read); a host acknowledge (cmd_i=1) drives SDA low during the acknowledge bit.
- R3: An address that does not match produces no acknowledge, no stretching and no pending flag for the address or for any later byte until the next START.
- R4: A host not-acknowledge (cmd_i=2) of a matched address leaves SDA released in the acknowledge bit, and later bytes of that transfer are ignored.
- R5: With cfg_hs_i=0, each received data byte stretches SCL before its acknowledge bit, with pend_o=1, stat_o=3 and rdata_o holding the byte; cmd_i=1 acknowledges it and cmd_i=2 does not.
- R6: As transmitter, the target sends cmd_data_i MSB first. After the controller's acknowledge bit, it stretches with stat_o=4 (acknowledged) or stat_o=5 (not acknowledged). cmd_i=3 after stat 4 sends the next byte; cmd_i=3 after stat 5 releases the bus.
- R7: With cfg_hs_i=1, each received data byte is acknowledged without host action, and SCL is stretched only after the acknowledge bit, with stat_o=3 and rdata_o valid; cmd_i=3 releases it. pad_hs_o stays 0 when no master code was seen.
- R8: With cfg_hs_i=1, an address-phase byte 0000_1xxx is not acknowledged and sets pad_hs_o. The programmed address is still matched after the following repeated START, and STOP clears pad_hs_o. With cfg_hs_i=0, such a byte leaves pad_hs_o at 0.
- R9: A START or repeated START during a byte aborts it and restarts address reception. STOP clears pend_o and stat_o and returns the target to idle.
- R10: The target asserts scl_oe_o only while SCL is already low, and changes sda_oe_o only while SCL is low.
- R11: A command given while pend_o is 0 has no effect on SDA, SCL or the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cfg_addr_i | input | 7 | Programmed target address |
| cfg_hs_i | input | 1 | HS-capable configuration |
| cmd_valid_i | input | 1 | Host command strobe, one cycle |
| cmd_i | input | 2 | 1 acknowledge, 2 not-acknowledge, 3 continue |
| cmd_data_i | input | 8 | Byte to transmit, taken with the command |
| pend_o | output | 1 | Host decision pending |
| stat_o | output | 3 | Event code of the pending decision |
| rdata_o | output | 8 | Last received data byte |
| pad_hs_o | output | 1 | Selects high-speed pad filtering and drive |

## Verification
The bench acts as the bus controller on a wired-AND bus model. It waits for SCL to rise after releasing it, so a target that fails to stretch, or never releases, shows up as a missing pending flag or a stalled run. It checks the acknowledge level in the ninth bit for host acknowledge, host not-acknowledge, non-matching addresses and automatic HS acknowledge. A design that acknowledged before the host answered, or that stretched before the automatic acknowledge, would read back the wrong level. A repeated START after four data bits must restart address matching, and the master code must set the pad control without being acknowledged. A design that counted bits across the abort, or that dropped the address after the code, would miss the later match. A monitor flags any stretch that starts while SCL is high and any SDA change while SCL is high.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int DW = 8;
  localparam int AW = 7;

  localparam logic [1:0] CMD_ACK  = 2'd1;
  localparam logic [1:0] CMD_NACK = 2'd2;
  localparam logic [1:0] CMD_CONT = 2'd3;

  localparam logic [2:0] EV_NONE  = 3'd0;
  localparam logic [2:0] EV_ADR_W = 3'd1;
  localparam logic [2:0] EV_ADR_R = 3'd2;
  localparam logic [2:0] EV_RX    = 3'd3;
  localparam logic [2:0] EV_TX_A  = 3'd4;
  localparam logic [2:0] EV_TX_N  = 3'd5;

  localparam logic [4:0] HS_PREFIX = 5'b00001;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AHOLD, ST_ACKO, ST_RX, ST_RHOLD,
    ST_RAUTO, ST_RAHOLD, ST_TX, ST_TACK, ST_THOLD, ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2ct_busmon.sv
module i2ct_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NL = 2;

  logic [NL-1:0] raw;
  logic [NL-1:0] synced;
  logic [NL-1:0] last;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i) begin
      if (rst_i) chain <= '1;
      else       chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) last <= '1;
    else       last <= synced;
  end

  assign scl_s_o    = synced[1];
  assign sda_s_o    = synced[0];
  assign scl_rise_o = synced[1] & ~last[1];
  assign scl_fall_o = ~synced[1] & last[1];
  assign start_o    = synced[1] & last[1] & last[0] & ~synced[0];
  assign stop_o     = synced[1] & last[1] & ~last[0] & synced[0];
endmodule

// File: rtl/i2ct_shifter.sv
module i2ct_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      cnt    <= '0;
      data_o <= '0;
    end else if (shift_i) begin
      data_o <= {data_o[W-2:0], bit_i};
      if (cnt != LAST) cnt <= cnt + 1'b1;
    end
  end

  assign full_o = (cnt == LAST);
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic          cfg_hs_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          pend_o,
  output logic [2:0]    stat_o,
  output logic [DW-1:0] rdata_o,
  output logic          pad_hs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [DW-1:0] rx_byte;
  logic          rx_full;
  logic          sh_clr;
  logic [DW-1:0] tx_sh;
  logic          is_read;
  logic          m_ack;
  tgt_state_e    state;

  i2ct_busmon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk_i(clk_i), .rst_i(rst_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_p), .stop_o(stop_p)
  );

  i2ct_shifter #(.W(DW)) u_sh (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(sh_clr), .shift_i(scl_rise),
    .bit_i(sda_s), .data_o(rx_byte), .full_o(rx_full)
  );

  wire cmd_ack  = cmd_valid_i && (cmd_i == CMD_ACK);
  wire cmd_nack = cmd_valid_i && (cmd_i == CMD_NACK);
  wire cmd_cont = cmd_valid_i && (cmd_i == CMD_CONT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
      pend_o   <= 1'b0;
      stat_o   <= EV_NONE;
      rdata_o  <= '0;
      pad_hs_o <= 1'b0;
      tx_sh    <= '0;
      is_read  <= 1'b0;
      m_ack    <= 1'b0;
      sh_clr   <= 1'b0;
    end else begin
      sh_clr <= 1'b0;
      if (stop_p) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
        pend_o   <= 1'b0;
        stat_o   <= EV_NONE;
        pad_hs_o <= 1'b0;
      end else if (start_p) begin
        state    <= ST_ADDR;
        sda_oe_o <= 1'b0;
        pend_o   <= 1'b0;
        stat_o   <= EV_NONE;
        sh_clr   <= 1'b1;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_fall && rx_full) begin
            if (rx_byte[DW-1:1] == cfg_addr_i) begin
              state   <= ST_AHOLD;
              pend_o  <= 1'b1;
              is_read <= rx_byte[0];
              stat_o  <= rx_byte[0] ? EV_ADR_R : EV_ADR_W;
            end else begin
              if (cfg_hs_i && rx_byte[DW-1:DW-5] == HS_PREFIX) pad_hs_o <= 1'b1;
              state <= ST_SKIP;
            end
          end
          ST_AHOLD: begin
            if (cmd_ack) begin
              sda_oe_o <= 1'b1;
              pend_o   <= 1'b0;
              tx_sh    <= cmd_data_i;
              state    <= ST_ACKO;
            end else if (cmd_nack) begin
              pend_o <= 1'b0;
              state  <= ST_SKIP;
            end
          end
          ST_ACKO: if (scl_fall) begin
            sh_clr <= 1'b1;
            if (is_read) begin
              sda_oe_o <= ~tx_sh[DW-1];
              tx_sh    <= {tx_sh[DW-2:0], 1'b0};
              state    <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= ST_RX;
            end
          end
          ST_RX: if (scl_fall && rx_full) begin
            rdata_o <= rx_byte;
            if (cfg_hs_i) begin
              sda_oe_o <= 1'b1;
              state    <= ST_RAUTO;
            end else begin
              pend_o <= 1'b1;
              stat_o <= EV_RX;
              state  <= ST_RHOLD;
            end
          end
          ST_RHOLD: begin
            if (cmd_ack) begin
              sda_oe_o <= 1'b1;
              pend_o   <= 1'b0;
              state    <= ST_ACKO;
            end else if (cmd_nack) begin
              pend_o <= 1'b0;
              state  <= ST_SKIP;
            end
          end
          ST_RAUTO: if (scl_fall) begin
            sda_oe_o <= 1'b0;
            pend_o   <= 1'b1;
            stat_o   <= EV_RX;
            state    <= ST_RAHOLD;
          end
          ST_RAHOLD: begin
            if (cmd_cont) begin
              pend_o <= 1'b0;
              sh_clr <= 1'b1;
              state  <= ST_RX;
            end else if (cmd_nack) begin
              pend_o <= 1'b0;
              state  <= ST_SKIP;
            end
          end
          ST_TX: if (scl_fall) begin
            if (rx_full) begin
              sda_oe_o <= 1'b0;
              state    <= ST_TACK;
            end else begin
              sda_oe_o <= ~tx_sh[DW-1];
              tx_sh    <= {tx_sh[DW-2:0], 1'b0};
            end
          end
          ST_TACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            if (scl_fall) begin
              pend_o <= 1'b1;
              stat_o <= m_ack ? EV_TX_A : EV_TX_N;
              state  <= ST_THOLD;
            end
          end
          ST_THOLD: begin
            if (cmd_cont && stat_o == EV_TX_A) begin
              pend_o   <= 1'b0;
              sda_oe_o <= ~cmd_data_i[DW-1];
              tx_sh    <= {cmd_data_i[DW-2:0], 1'b0};
              sh_clr   <= 1'b1;
              state    <= ST_TX;
            end else if (cmd_cont || cmd_nack) begin
              pend_o <= 1'b0;
              state  <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // SCL is released one cycle after SDA has settled for the next bit.
  always_ff @(posedge clk_i) begin
    if (rst_i) scl_oe_o <= 1'b0;
    else scl_oe_o <= (state == ST_AHOLD) || (state == ST_RHOLD) ||
                     (state == ST_RAHOLD) || (state == ST_THOLD);
  end

  // R10: stretching begins only while the line is already low
  a_r10_stretch_low: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(scl_oe_o) |-> !scl_s);

  // R10: SDA drive changes only while SCL is low (bus conditions excepted)
  a_r10_sda_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(sda_oe_o) && !$past(start_p) && !$past(stop_p)) |-> !$past(scl_s));

  // R2: a pending decision always holds the clock
  a_r2_pend_stretch: assert property (@(posedge clk_i) disable iff (rst_i)
    pend_o |=> scl_oe_o);

  // R9: STOP clears the pending flag and the status
  a_r9_stop_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_p |=> (!pend_o && stat_o == EV_NONE));

  // R8: pad control only switches on in HS-capable configuration
  a_r8_hs_cfg: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pad_hs_o) |-> cfg_hs_i);

  // R7: with automatic acknowledge the ack bit is over when the host is asked
  a_r7_auto_ack_done: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_hs_i && pend_o && stat_o == EV_RX) |-> !sda_oe_o);
endmodule

// File: tb/i2ct_target_tb.sv
module i2ct_target_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, pend, pad_hs;
  logic [6:0] cfg_addr = 7'h3C;
  logic cfg_hs = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic [2:0] stat;
  logic [7:0] rdata;
  wire scl_bus = scl_m & ~scl_oe;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0, viol = 0, cycles = 0;

  always #5 clk = ~clk;

  i2ct_target dut_i (
    .clk_i(clk), .rst_i(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .cfg_addr_i(cfg_addr),
    .cfg_hs_i(cfg_hs), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .cmd_data_i(cmd_data), .pend_o(pend), .stat_o(stat),
    .rdata_o(rdata), .pad_hs_o(pad_hs)
  );

  // R10 monitor: stretch start or SDA change while SCL is high
  logic prev_scl_oe = 1'b0, prev_sda_oe = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (scl_oe && !prev_scl_oe && scl_m) viol++;
      if (sda_oe != prev_sda_oe && scl_bus) viol++;
    end
    prev_scl_oe = scl_oe;
    prev_sda_oe = sda_oe;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wait_high(); wq(Q/2);
    r = sda_bus; wq(Q/2);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic m_start();
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic m_rstart();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wait_high(); wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wait_high(); wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic m_send8(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(v[i], r);
  endtask

  task automatic m_recv8(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      m_bit(1'b1, r);
      v[i] = r;
    end
  endtask

  task automatic host(input logic [1:0] c, input logic [7:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd = c; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0; wq(2);
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 pend", pend, 0);
    chk("R1 stat", stat, 0);
    chk("R1 pad_hs", pad_hs, 0);
  endtask

  task automatic t_idle_cmd();
    host(2'd1, 8'hFF);
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 scl_oe", scl_oe, 0);
    chk("R11 pend", pend, 0);
  endtask

  task automatic t_nomatch();
    logic r;
    m_start(); m_send8({7'h2A, 1'b0});
    chk("R3 pend", pend, 0);
    m_bit(1'b1, r); chk("R3 no ack", r, 1);
    m_send8(8'h00); m_bit(1'b1, r);
    chk("R3 data ignored", r, 1);
    chk("R3 pend after data", pend, 0);
    m_stop();
  endtask

  task automatic t_write();
    logic r;
    m_start(); m_send8({7'h3C, 1'b0});
    chk("R2 pend", pend, 1);
    chk("R2 stat write", stat, 1);
    chk("R2 stretch", scl_oe, 1);
    host(2'd1, 8'h00);
    m_bit(1'b1, r); chk("R2 ack", r, 0);
    m_send8(8'hA5);
    chk("R5 pend", pend, 1);
    chk("R5 stat", stat, 3);
    chk("R5 rdata", rdata, 8'hA5);
    chk("R5 stretch", scl_oe, 1);
    host(2'd1, 8'h00);
    m_bit(1'b1, r); chk("R5 ack", r, 0);
    m_send8(8'h5A);
    chk("R5 rdata2", rdata, 8'h5A);
    host(2'd2, 8'h00);
    m_bit(1'b1, r); chk("R5 nack", r, 1);
    m_stop();
    chk("R9 pend after stop", pend, 0);
  endtask

  task automatic t_addr_nack();
    logic r;
    m_start(); m_send8({7'h3C, 1'b0});
    chk("R4 pend", pend, 1);
    host(2'd2, 8'h00);
    m_bit(1'b1, r); chk("R4 nack", r, 1);
    m_send8(8'h77); m_bit(1'b1, r);
    chk("R4 data ignored", r, 1);
    chk("R4 pend", pend, 0);
    m_stop();
  endtask

  task automatic t_read();
    logic r;
    logic [7:0] v;
    m_start(); m_send8({7'h3C, 1'b1});
    chk("R2 stat read", stat, 2);
    host(2'd1, 8'hC3);
    m_bit(1'b1, r); chk("R2 read ack", r, 0);
    m_recv8(v); chk("R6 byte0", v, 8'hC3);
    m_bit(1'b0, r);
    chk("R6 pend", pend, 1);
    chk("R6 stat acked", stat, 4);
    chk("R6 stretch", scl_oe, 1);
    host(2'd3, 8'h96);
    m_recv8(v); chk("R6 byte1", v, 8'h96);
    m_bit(1'b1, r);
    chk("R6 stat nacked", stat, 5);
    host(2'd3, 8'h00);
    chk("R6 released", scl_oe, 0);
    chk("R6 sda free", sda_oe, 0);
    m_stop();
  endtask

  task automatic t_hs_rx();
    logic r;
    cfg_hs = 1'b1;
    m_start(); m_send8({7'h3C, 1'b0});
    chk("R7 addr stat", stat, 1);
    host(2'd1, 8'h00);
    m_bit(1'b1, r);
    m_send8(8'h3E);
    chk("R7 no stretch before ack", scl_oe, 0);
    chk("R7 no pend before ack", pend, 0);
    m_bit(1'b1, r); chk("R7 auto ack", r, 0);
    chk("R7 pend", pend, 1);
    chk("R7 stat", stat, 3);
    chk("R7 rdata", rdata, 8'h3E);
    chk("R7 stretch", scl_oe, 1);
    chk("R7 pad normal", pad_hs, 0);
    host(2'd3, 8'h00);
    m_send8(8'h81); m_bit(1'b1, r);
    chk("R7 auto ack2", r, 0);
    chk("R7 rdata2", rdata, 8'h81);
    host(2'd3, 8'h00);
    m_stop();
  endtask

  task automatic t_hs_code();
    logic r;
    cfg_hs = 1'b1;
    m_start(); m_send8(8'h0B);
    m_bit(1'b1, r); chk("R8 code not acked", r, 1);
    chk("R8 pad hs", pad_hs, 1);
    chk("R8 pend", pend, 0);
    m_rstart(); m_send8({7'h3C, 1'b0});
    chk("R8 match after code", stat, 1);
    chk("R8 pad kept", pad_hs, 1);
    host(2'd1, 8'h00);
    m_bit(1'b1, r); chk("R8 ack", r, 0);
    m_stop();
    chk("R8 pad after stop", pad_hs, 0);
    cfg_hs = 1'b0;
    m_start(); m_send8(8'h0B); m_bit(1'b1, r);
    chk("R8 no pad when not capable", pad_hs, 0);
    m_stop();
  endtask

  task automatic t_abort();
    logic r;
    m_start(); m_send8({7'h3C, 1'b0});
    host(2'd1, 8'h00);
    m_bit(1'b1, r);
    for (int i = 0; i < 4; i++) m_bit(1'b1, r);
    m_rstart(); m_send8({7'h3C, 1'b1});
    chk("R9 restart pend", pend, 1);
    chk("R9 restart stat", stat, 2);
    host(2'd2, 8'h00);
    m_bit(1'b1, r);
    m_stop();
    chk("R9 stop pend", pend, 0);
    chk("R9 stop stat", stat, 0);
    chk("R9 stop scl", scl_oe, 0);
  endtask

  initial begin
    wq(4); rst = 1'b0; wq(4);
    t_reset();
    t_idle_cmd();
    t_nomatch();
    t_write();
    t_addr_nack();
    t_read();
    t_hs_rx();
    t_hs_code();
    t_abort();
    chk("R10 bus rules", viol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule